// File: doc/BRIEF.md
# SD Card Single-Line Data Path Controller

This block moves data blocks between a host and a memory card over one serial data line. Software programs a transfer with a single write strobe. The strobe carries a byte count, a block size in bytes, a start-bit timeout in bus clocks, a direction bit and a block/stream mode bit. The controller then runs one transfer to completion or to an error.

When the card sends data, the controller waits for a start bit and shifts the serial bits into bytes. It pushes each byte into an external receive FIFO. In block mode it also checks the 16-bit CRC that trails each block.

When the host sends data, the controller pops bytes from an external transmit FIFO. It frames each block with a start bit, the data, the CRC and an end bit, and drives the line only during the frame. Four sticky flags report the outcome: normal completion, start-bit timeout, CRC mismatch and receive overrun.

Top module: `sdc_datapath`

## Requirements
- R1: While idle, `sd_oe` is low. A `cfg_wr` pulse with `cfg_en`=1 accepted in idle starts a transfer of `cfg_len` bytes. A `cfg_wr` pulse with `cfg_en`=0 starts nothing.
- R2: `cfg_dir`=1 selects card-to-host (receive). `cfg_dir`=0 selects host-to-card (send). A receive never drives the line, and a send never pushes into the receive FIFO.
- R3: In the receive wait state with no bytes left, the controller returns to idle once `rx_empty` is high. On that return it sets the done flag.
- R4: A receive wait is entered on clock edge E0, with timeout value T. If `sd_di` has not been sampled low by edge E(T+1), the timeout flag is set on that edge and the controller goes idle. The flag is still clear after edge E(T).
- R5: In the receive state, the controller samples one bit per clock, most significant bit first. Each completed byte appears on `rx_data` with `rx_push` high.
- R6: If a byte completes while `rx_full` is high, the byte is not pushed. The overrun flag is set and the controller goes idle.
- R7: In block mode, `cfg_blksz` data bytes are followed by 16 CRC bits, MSB first. On a match the controller waits for the next block. On a mismatch it sets the CRC flag and goes idle.
- R8: In stream mode, the controller receives `cfg_len` bytes back to back with no CRC, then returns to the receive wait state.
- R9: In the send wait state, a zero remaining count returns the controller to idle and sets the done flag. Otherwise the controller stays put, with the line released, while `tx_empty` is high.
- R10: A send frame is a 0 start bit, then data MSB first, then (block mode only) the 16 CRC bits, then a 1 end bit. `sd_oe` is high for exactly the frame's bits. A block-mode frame carries `cfg_blksz` bytes. A stream-mode frame carries all `cfg_len` bytes.
- R11: The CRC uses the polynomial x^16+x^12+x^5+1, starts at zero and covers only the data bits of one block.
- R12: The `flags` bits are [0] done, [1] timeout, [2] CRC error and [3] overrun. Each flag stays set until `clr_wr` is high with the matching `clr_mask` bit set. A flag being set in the same cycle wins over its clear.
- R13: The done flag is set only when a transfer ends without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one data bit per cycle |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Start enable carried by the write |
| cfg_dir | input | 1 | 1 = receive from card, 0 = send to card |
| cfg_stream | input | 1 | 1 = stream mode, 0 = block mode |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_blksz | input | BLK_W | Block size in bytes |
| cfg_tmo | input | TMO_W | Start-bit timeout in bus clocks |
| clr_wr | input | 1 | Flag clear strobe |
| clr_mask | input | 4 | Flags to clear |
| sd_di | input | 1 | Serial data from the card |
| sd_do | output | 1 | Serial data to the card |
| sd_oe | output | 1 | Line drive enable |
| rx_push | output | 1 | Receive FIFO write |
| rx_data | output | 8 | Receive FIFO write data |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| tx_pop | output | 1 | Transmit FIFO read (show-ahead data) |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_empty | input | 1 | Transmit FIFO empty |
| flags | output | 4 | Sticky status flags |

## Verification
A wrong state, counter or shift register shows up at the ports within one block period. It appears as a misplaced or corrupted byte on `rx_data`, or as a wrong bit in the serialised send frame. It can also appear as a flag that rises one edge early or late.

The timeout path is pinned to an exact edge, so an off-by-one in the countdown appears as a flag mismatch in a single cycle. A CRC or bit-order fault corrupts every block. It therefore surfaces at the first block's trailing bits on send, or as a spurious CRC flag on receive.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_R,
        ST_RECV,
        ST_RCRC,
        ST_WAIT_S,
        ST_TX_START,
        ST_TX_DATA,
        ST_TX_CRC,
        ST_TX_END
    } sdc_state_e;

    localparam int FLG_W   = 4;
    localparam int FLG_END = 0;
    localparam int FLG_TMO = 1;
    localparam int FLG_CRC = 2;
    localparam int FLG_OVR = 3;
endpackage

// File: rtl/sdc_crc16.sv
// One serial step of an MSB-first CRC with zero-based shift register.
module sdc_crc16 #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = crc_i[W-1] ^ bit_i;
        crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/sdc_tmo.sv
// Start-bit timeout down-counter; reloads on load_i, counts while run_i.
module sdc_tmo #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         run_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (run_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath
    import sdc_pkg::*;
#(
    parameter int              LEN_W    = 16,
    parameter int              BLK_W    = 12,
    parameter int              TMO_W    = 16,
    parameter int              CRC_W    = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic             cfg_dir,
    input  logic             cfg_stream,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [BLK_W-1:0] cfg_blksz,
    input  logic [TMO_W-1:0] cfg_tmo,
    input  logic             clr_wr,
    input  logic [3:0]       clr_mask,
    input  logic             sd_di,
    output logic             sd_do,
    output logic             sd_oe,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    input  logic             rx_full,
    input  logic             rx_empty,
    output logic             tx_pop,
    input  logic [7:0]       tx_data,
    input  logic             tx_empty,
    output logic [3:0]       flags
);
    localparam int BIT_W = $clog2(CRC_W);
    localparam logic [BIT_W-1:0] LAST_DBIT = BIT_W'(7);
    localparam logic [BIT_W-1:0] LAST_CBIT = BIT_W'(CRC_W - 1);

    typedef struct packed {
        sdc_state_e       st;
        logic [LEN_W-1:0] dcnt;
        logic [BLK_W-1:0] bcnt;
        logic [BLK_W-1:0] blksz;
        logic [TMO_W-1:0] tmo_val;
        logic             stream;
        logic [BIT_W-1:0] bitn;
        logic [7:0]       sh;
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] crc_rx;
        logic [FLG_W-1:0] flg;
    } regs_t;

    regs_t            r_d, r_q;
    logic [CRC_W-1:0] crc_nx;
    logic             crc_bit;
    logic             tmo_load;
    logic             tmo_exp;
    logic [TMO_W-1:0] tmo_src;
    logic [FLG_W-1:0] set_f;
    logic [7:0]       byte_in;

    assign crc_bit = (r_q.st == ST_RECV) ? sd_di : r_q.sh[7];
    assign tmo_src = (r_q.st == ST_IDLE) ? cfg_tmo : r_q.tmo_val;
    assign byte_in = {r_q.sh[6:0], sd_di};

    sdc_crc16 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i (r_q.crc),
        .bit_i (crc_bit),
        .crc_o (crc_nx)
    );

    sdc_tmo #(.W(TMO_W)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmo_load),
        .val_i     (tmo_src),
        .run_i     (r_q.st == ST_WAIT_R),
        .expired_o (tmo_exp)
    );

    always_comb begin
        r_d      = r_q;
        rx_push  = 1'b0;
        rx_data  = byte_in;
        tx_pop   = 1'b0;
        sd_oe    = 1'b0;
        sd_do    = 1'b1;
        tmo_load = 1'b0;
        set_f    = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (cfg_wr && cfg_en) begin
                    r_d.dcnt    = cfg_len;
                    r_d.blksz   = cfg_blksz;
                    r_d.stream  = cfg_stream;
                    r_d.tmo_val = cfg_tmo;
                    if (cfg_dir) begin
                        r_d.st   = ST_WAIT_R;
                        tmo_load = 1'b1;
                    end else begin
                        r_d.st = ST_WAIT_S;
                    end
                end
            end
            ST_WAIT_R: begin
                if (r_q.dcnt == '0) begin
                    if (rx_empty) begin
                        r_d.st         = ST_IDLE;
                        set_f[FLG_END] = 1'b1;
                    end
                end else if (!sd_di) begin
                    r_d.st   = ST_RECV;
                    r_d.bcnt = r_q.blksz;
                    r_d.bitn = '0;
                    r_d.crc  = '0;
                end else if (tmo_exp) begin
                    r_d.st         = ST_IDLE;
                    set_f[FLG_TMO] = 1'b1;
                end
            end
            ST_RECV: begin
                r_d.crc  = crc_nx;
                r_d.sh   = byte_in;
                r_d.bitn = r_q.bitn + 1'b1;
                if (r_q.bitn == LAST_DBIT) begin
                    r_d.bitn = '0;
                    if (rx_full) begin
                        r_d.st         = ST_IDLE;
                        set_f[FLG_OVR] = 1'b1;
                    end else begin
                        rx_push  = 1'b1;
                        r_d.dcnt = r_q.dcnt - 1'b1;
                        r_d.bcnt = r_q.bcnt - 1'b1;
                        if (r_q.stream) begin
                            if (r_q.dcnt == LEN_W'(1)) begin
                                r_d.st   = ST_WAIT_R;
                                tmo_load = 1'b1;
                            end
                        end else if (r_q.bcnt == BLK_W'(1)) begin
                            r_d.st     = ST_RCRC;
                            r_d.crc_rx = '0;
                        end
                    end
                end
            end
            ST_RCRC: begin
                r_d.crc_rx = {r_q.crc_rx[CRC_W-2:0], sd_di};
                r_d.bitn   = r_q.bitn + 1'b1;
                if (r_q.bitn == LAST_CBIT) begin
                    r_d.bitn = '0;
                    if ({r_q.crc_rx[CRC_W-2:0], sd_di} == r_q.crc) begin
                        r_d.st   = ST_WAIT_R;
                        tmo_load = 1'b1;
                    end else begin
                        r_d.st         = ST_IDLE;
                        set_f[FLG_CRC] = 1'b1;
                    end
                end
            end
            ST_WAIT_S: begin
                if (r_q.dcnt == '0) begin
                    r_d.st         = ST_IDLE;
                    set_f[FLG_END] = 1'b1;
                end else if (!tx_empty) begin
                    r_d.st = ST_TX_START;
                end
            end
            ST_TX_START: begin
                sd_oe    = 1'b1;
                sd_do    = 1'b0;
                tx_pop   = 1'b1;
                r_d.sh   = tx_data;
                r_d.bcnt = r_q.blksz;
                r_d.bitn = '0;
                r_d.crc  = '0;
                r_d.st   = ST_TX_DATA;
            end
            ST_TX_DATA: begin
                sd_oe    = 1'b1;
                sd_do    = r_q.sh[7];
                r_d.crc  = crc_nx;
                r_d.sh   = {r_q.sh[6:0], 1'b0};
                r_d.bitn = r_q.bitn + 1'b1;
                if (r_q.bitn == LAST_DBIT) begin
                    r_d.bitn = '0;
                    r_d.dcnt = r_q.dcnt - 1'b1;
                    r_d.bcnt = r_q.bcnt - 1'b1;
                    if (r_q.stream && r_q.dcnt == LEN_W'(1)) begin
                        r_d.st = ST_TX_END;
                    end else if (!r_q.stream && r_q.bcnt == BLK_W'(1)) begin
                        r_d.st = ST_TX_CRC;
                    end else begin
                        tx_pop = 1'b1;
                        r_d.sh = tx_data;
                    end
                end
            end
            ST_TX_CRC: begin
                sd_oe    = 1'b1;
                sd_do    = r_q.crc[CRC_W-1];
                r_d.crc  = {r_q.crc[CRC_W-2:0], 1'b0};
                r_d.bitn = r_q.bitn + 1'b1;
                if (r_q.bitn == LAST_CBIT) begin
                    r_d.bitn = '0;
                    r_d.st   = ST_TX_END;
                end
            end
            ST_TX_END: begin
                sd_oe  = 1'b1;
                sd_do  = 1'b1;
                r_d.st = ST_WAIT_S;
            end
            default: r_d.st = ST_IDLE;
        endcase

        r_d.flg = (r_q.flg & ~(clr_wr ? clr_mask : '0)) | set_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flags = r_q.flg;

    AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !sd_oe); // R1
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_oe) |-> !sd_do); // R10
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_oe) |-> $past(sd_do)); // R10
    AST_POP_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> sd_oe); // R10
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R6
    AST_TMO_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_TMO]) |-> ($past(r_q.st) == ST_WAIT_R)); // R4
    AST_CRC_FROM_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_CRC]) |-> ($past(r_q.st) == ST_RCRC)); // R7
endmodule

// File: tb/sdc_datapath_bench.sv
module sdc_datapath_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_en = 1'b0, cfg_dir = 1'b0, cfg_stream = 1'b0;
    logic [15:0] cfg_len = '0;
    logic [11:0] cfg_blksz = '0;
    logic [15:0] cfg_tmo = '0;
    logic        clr_wr = 1'b0;
    logic [3:0]  clr_mask = '0;
    logic        sd_di = 1'b1;
    logic        sd_do, sd_oe, rx_push, tx_pop;
    logic [7:0]  rx_data, tx_data;
    logic        rx_full = 1'b0, rx_empty = 1'b1, tx_empty;
    logic [3:0]  flags;

    int nchk = 0, nerr = 0;
    logic [7:0] pat [0:31];
    logic [7:0] rxq [0:31];
    logic       txb [0:255];
    logic       expb [0:255];
    int rxn = 0, txn = 0, tx_rp = 0, tx_cnt = 0;
    logic cap_clr = 1'b0;

    always #2 clk = ~clk;

    sdc_datapath u_sdc_datapath (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
        .cfg_stream(cfg_stream), .cfg_len(cfg_len), .cfg_blksz(cfg_blksz), .cfg_tmo(cfg_tmo),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .sd_di(sd_di), .sd_do(sd_do), .sd_oe(sd_oe),
        .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty), .flags(flags)
    );

    assign tx_empty = (tx_rp >= tx_cnt);
    assign tx_data  = pat[tx_rp & 31];

    always @(posedge clk) begin
        if (cap_clr)     tx_rp <= 0;
        else if (tx_pop) tx_rp <= tx_rp + 1;
    end

    always @(negedge clk) begin
        if (cap_clr) begin
            rxn = 0;
            txn = 0;
        end else begin
            if (rx_push) begin rxq[rxn & 31] = rx_data; rxn++; end
            if (sd_oe)   begin txb[txn & 255] = sd_do; txn++; end
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_of(input int first, input int n);
        logic [15:0] c = '0;
        for (int i = first; i < first + n; i++)
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[15] ^ pat[i][b];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        return c;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_bit(input logic b);
        @(posedge clk); #1 sd_di = b;
    endtask

    task automatic clear_cap();
        @(posedge clk); #1 cap_clr = 1'b1;
        @(posedge clk); #1 cap_clr = 1'b0;
    endtask

    task automatic clr_flags(input logic [3:0] m);
        @(posedge clk); #1 clr_wr = 1'b1; clr_mask = m;
        @(posedge clk); #1 clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic start(input logic en, input logic dir, input logic strm,
                         input int len, input int bsz, input int tmo);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_en = en; cfg_dir = dir; cfg_stream = strm;
        cfg_len = 16'(len); cfg_blksz = 12'(bsz); cfg_tmo = 16'(tmo);
        @(posedge clk); #1 cfg_wr = 1'b0;
    endtask

    task automatic send_frame(input int first, input int n, input logic use_crc, input logic bad);
        logic [15:0] c = crc_of(first, n) ^ {15'd0, bad};
        drive_bit(1'b0);
        for (int i = first; i < first + n; i++)
            for (int b = 7; b >= 0; b--) drive_bit(pat[i][b]);
        if (use_crc) for (int b = 15; b >= 0; b--) drive_bit(c[b]);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic build_tx_expect(input int nblk, input int bsz, input logic use_crc, output int len);
        int k = 0;
        for (int blk = 0; blk < nblk; blk++) begin
            logic [15:0] c = crc_of(blk * bsz, bsz);
            expb[k++] = 1'b0;
            for (int i = blk * bsz; i < (blk + 1) * bsz; i++)
                for (int b = 7; b >= 0; b--) expb[k++] = pat[i][b];
            if (use_crc) for (int b = 15; b >= 0; b--) expb[k++] = c[b];
            expb[k++] = 1'b1;
        end
        len = k;
    endtask

    task automatic compare_tx(input string req, input int len);
        int bad = 0;
        check_eq({req, " frame bit count"}, txn, len);
        for (int i = 0; i < len; i++) if (txb[i] !== expb[i]) bad++;
        check_eq({req, " mismatching frame bits"}, bad, 0);
    endtask

    task automatic t_reset();
        cyc(1);
        check_eq("R12 flags after reset", int'(flags), 0);
        check_eq("R1 line released after reset", int'(sd_oe), 0);
        check_eq("R5 no push after reset", int'(rx_push), 0);
    endtask

    task automatic t_rx_block();
        for (int i = 0; i < 4; i++) pat[i] = 8'(8'hA5 ^ (i * 8'h3C));
        clear_cap();
        start(1, 1, 0, 4, 2, 200);
        send_frame(0, 2, 1, 0);
        send_frame(2, 2, 1, 0);
        cyc(4);
        check_eq("R5 bytes pushed in block mode", rxn, 4);
        for (int i = 0; i < 4; i++) check_eq("R5 R11 received byte value", int'(rxq[i]), int'(pat[i]));
        check_eq("R7 R11 no CRC flag on good blocks", int'(flags[2]), 0);
        check_eq("R3 R13 done flag after receive", int'(flags[0]), 1);
        check_eq("R2 receive never drives line", txn, 0);
        clr_flags(4'hF);
    endtask

    task automatic t_rx_badcrc();
        pat[0] = 8'h00; pat[1] = 8'hFF;
        clear_cap();
        start(1, 1, 0, 2, 2, 200);
        send_frame(0, 2, 1, 1);
        cyc(4);
        check_eq("R7 CRC flag on mismatch", int'(flags[2]), 1);
        check_eq("R13 no done flag after CRC error", int'(flags[0]), 0);
        check_eq("R7 data bytes still pushed", rxn, 2);
        clr_flags(4'hF);
    endtask

    task automatic t_rx_stream();
        pat[0] = 8'h81; pat[1] = 8'h7E; pat[2] = 8'h5A;
        clear_cap();
        start(1, 1, 1, 3, 1, 200);
        send_frame(0, 3, 0, 0);
        cyc(4);
        check_eq("R8 stream byte count", rxn, 3);
        check_eq("R8 stream last byte", int'(rxq[2]), 8'h5A);
        check_eq("R8 R13 stream done, no CRC flag", int'(flags), 1);
        clr_flags(4'hF);
    endtask

    task automatic t_timeout_and_clear();
        start(1, 1, 0, 4, 2, 10);
        cyc(10);
        check_eq("R4 timeout flag still clear after edge T", int'(flags[1]), 0);
        cyc(1);
        check_eq("R4 timeout flag set on edge T+1", int'(flags[1]), 1);
        check_eq("R13 no done after timeout", int'(flags[0]), 0);
        clr_flags(4'b0001);
        cyc(1);
        check_eq("R12 unrelated clear keeps timeout flag", int'(flags[1]), 1);
        clr_flags(4'b0010);
        cyc(1);
        check_eq("R12 matching clear drops timeout flag", int'(flags[1]), 0);
    endtask

    task automatic t_overrun();
        pat[0] = 8'hC3;
        clear_cap();
        rx_full = 1'b1;
        start(1, 1, 1, 1, 1, 200);
        send_frame(0, 1, 0, 0);
        cyc(4);
        check_eq("R6 overrun flag set", int'(flags[3]), 1);
        check_eq("R6 no push while full", rxn, 0);
        check_eq("R13 no done after overrun", int'(flags[0]), 0);
        rx_full = 1'b0;
        clr_flags(4'hF);
    endtask

    task automatic t_tx_block();
        int len;
        for (int i = 0; i < 4; i++) pat[i] = 8'(8'h13 + i * 8'h47);
        clear_cap();
        tx_cnt = 4;
        start(1, 0, 0, 4, 2, 0);
        cyc(100);
        build_tx_expect(2, 2, 1, len);
        compare_tx("R10 R11 block send", len);
        check_eq("R9 done flag after send", int'(flags), 1);
        check_eq("R2 send pushes nothing", rxn, 0);
        check_eq("R1 line released after send", int'(sd_oe), 0);
        clr_flags(4'hF);
    endtask

    task automatic t_tx_wait_stream();
        int len;
        pat[0] = 8'hE7; pat[1] = 8'h18;
        clear_cap();
        tx_cnt = 0;
        start(1, 0, 1, 2, 1, 0);
        cyc(20);
        check_eq("R9 no drive while transmit FIFO empty", txn, 0);
        check_eq("R9 not done while waiting", int'(flags[0]), 0);
        tx_cnt = 2;
        cyc(40);
        build_tx_expect(1, 2, 0, len);
        compare_tx("R10 stream send", len);
        check_eq("R9 stream send done", int'(flags[0]), 1);
        clr_flags(4'hF);
    endtask

    task automatic t_ignore_disabled();
        clear_cap();
        start(0, 1, 0, 4, 2, 3);
        cyc(20);
        check_eq("R1 disabled write starts nothing (no timeout)", int'(flags), 0);
        start(0, 0, 0, 4, 2, 0);
        tx_cnt = 4;
        cyc(20);
        check_eq("R1 disabled write starts no send", txn, 0);
        tx_cnt = 0;
        clear_cap();
    endtask

    task automatic t_zero_len();
        clear_cap();
        start(1, 1, 0, 0, 2, 200);
        cyc(3);
        check_eq("R3 zero-length receive done", int'(flags[0]), 1);
        clr_flags(4'hF);
        rx_empty = 1'b0;
        start(1, 1, 0, 0, 2, 200);
        cyc(5);
        check_eq("R3 waits for empty receive FIFO", int'(flags[0]), 0);
        rx_empty = 1'b1;
        cyc(2);
        check_eq("R3 done after FIFO drains", int'(flags[0]), 1);
        clr_flags(4'hF);
        start(1, 0, 0, 0, 2, 0);
        cyc(3);
        check_eq("R9 zero-length send done", int'(flags[0]), 1);
        check_eq("R9 zero-length send never drives", txn, 0);
        clr_flags(4'hF);
    endtask

    bit finished = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_rx_block();
        t_rx_badcrc();
        t_rx_stream();
        t_timeout_and_clear();
        t_overrun();
        t_tx_block();
        t_tx_wait_stream();
        t_ignore_disabled();
        t_zero_len();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule